// File: doc/BRIEF.md
# Fast A20 and INIT System Control Port

This block is the single-byte system control register that software writes to in order to gate address line 20 or to request a processor INIT. It stores one A20 gate bit and drives it out as `a20Gate`. When the bit is 1, A20 passes through unmodified. When it is 0, the second megabyte wraps onto the first. A write with bit 0 set requests an INIT. The INIT also forces the gate bit to 1.

The block raises a one-clock interrupt request only when something happens: an INIT, or a write that actually changes the gate bit. Writes that leave the gate bit as it was produce no request. A read returns only the stored gate bit, in bit position 1. An enable mask input gates every effect of a write.

This register is the only source of the gate value. The block keeps no link to any A20 state held by a keyboard-controller path, in either direction.

Top module: `fastA20Port`

## Requirements
- R1: After reset, `a20Gate` is 1, `rdData` is 02h, and `initPulse` and `irqPulse` are 0.
- R2: An enabled write whose bit 0 is 1 makes `initPulse` high in the cycle after the write clock edge.
- R3: An enabled write whose bit 0 is 0 stores its bit 1 as the gate bit. `a20Gate` shows the new value after the write edge.
- R4: An INIT write sets the gate bit to 1 whatever its bit 1 holds, so INIT takes priority over a gate change in the same write.
- R5: `irqPulse` is raised only for an INIT or for a write that changes the gate bit. A write that leaves the gate bit unchanged raises nothing.
- R6: `initPulse` and `irqPulse` each last exactly one clock per triggering write.
- R7: Bits 7..2 of a write have no effect on any output.
- R8: `rdData` is always 00h or 02h, with bit 1 equal to the stored gate bit and all other bits 0.
- R9: While `portEnable` is 0, writes are ignored. The gate bit stays unchanged and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for this register |
| wrData | input | 8 | Write data byte |
| portEnable | input | 1 | Enable mask; 0 blocks all write effects |
| rdData | output | 8 | Read value, 00h or 02h |
| a20Gate | output | 1 | A20 gate (1 = pass through) |
| initPulse | output | 1 | One-clock processor INIT request |
| irqPulse | output | 1 | One-clock interrupt request on INIT or A20 change |

## Verification
A write is sampled at one rising edge. The new `a20Gate`, `rdData`, `initPulse` and `irqPulse` all appear after that same edge, one register stage in all. The pulses fall after the next edge unless a new write triggers them again. The bench's reference model advances on the same edge from the same sampled inputs. It compares all four outputs a quarter period later, on every clock, so each result is checked in the cycle it is due and in the following cycle, where it must be gone.

// File: rtl/a20InitPkg.sv
package a20InitPkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic loadGate;
    logic gateVal;
    logic fireInit;
    logic fireIrq;
  } ctrlStrobeT;
endpackage

// File: rtl/a20InitCtrl.sv
module a20InitCtrl
  import a20InitPkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int INIT_BIT = 0,
  parameter int GATE_BIT = 1
) (
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          portEnable,
  input  logic          curGate,
  output ctrlStrobeT    strobes
);
  logic accepted;
  logic initReq;
  logic gateDiff;

  assign accepted = wrEn & portEnable;
  assign initReq  = accepted & wrData[INIT_BIT];
  assign gateDiff = accepted & ~wrData[INIT_BIT] & (wrData[GATE_BIT] != curGate);

  always_comb begin
    strobes = '0;
    if (initReq) begin
      // INIT wins over a same-write gate change and leaves the gate high (R4)
      strobes.loadGate = 1'b1;
      strobes.gateVal  = 1'b1;
      strobes.fireInit = 1'b1;
      strobes.fireIrq  = 1'b1;
    end else if (gateDiff) begin
      strobes.loadGate = 1'b1;
      strobes.gateVal  = wrData[GATE_BIT];
      strobes.fireIrq  = 1'b1;
    end
  end
endmodule

// File: rtl/a20InitDatapath.sv
module a20InitDatapath
  import a20InitPkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int GATE_BIT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeT    strobes,
  input  logic          wrEn,
  input  logic          portEnable,
  output logic          gateBit,
  output logic          initPulse,
  output logic          irqPulse,
  output logic [DW-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateBit   <= 1'b1;
      initPulse <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (strobes.loadGate) gateBit <= strobes.gateVal;
      initPulse <= strobes.fireInit;
      irqPulse  <= strobes.fireIrq;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[GATE_BIT] = gateBit;
  end

  a_r4_init_gate_high: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |-> gateBit);

  a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (initPulse || (gateBit != $past(gateBit))));

  a_r5_change_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    (gateBit != $past(gateBit)) |-> irqPulse);

  a_r9_masked_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && portEnable) |-> (!irqPulse && !initPulse && $stable(gateBit)));

  a_r2_init_implies_irq: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |-> irqPulse);

  always_comb begin
    if (rstN) a_r8_read_shape: assert (rdData == 8'h00 || rdData == 8'h02);
  end
endmodule

// File: rtl/fastA20Port.sv
module fastA20Port
  import a20InitPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              portEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              a20Gate,
  output logic              initPulse,
  output logic              irqPulse
);
  ctrlStrobeT strobes;
  logic       gateBit;

  a20InitCtrl #(.DW(DATA_W)) ctrl_i (
    .wrEn      (wrEn),
    .wrData    (wrData),
    .portEnable(portEnable),
    .curGate   (gateBit),
    .strobes   (strobes)
  );

  a20InitDatapath #(.DW(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrEn      (wrEn),
    .portEnable(portEnable),
    .gateBit   (gateBit),
    .initPulse (initPulse),
    .irqPulse  (irqPulse),
    .rdData    (rdData)
  );

  assign a20Gate = gateBit;
endmodule

// File: tb/fastA20Port_tb.sv
module fastA20Port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       portEnable = 1'b1;
  logic [7:0] rdData;
  logic       a20Gate, initPulse, irqPulse;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit   done = 1'b0;

  bit mA20 = 1'b1, mInit = 1'b0, mIrq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastA20Port dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .portEnable(portEnable), .rdData(rdData), .a20Gate(a20Gate),
    .initPulse(initPulse), .irqPulse(irqPulse)
  );

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: advances on each edge from the sampled inputs
  always @(posedge clk) begin
    if (!rstN) begin
      mA20 = 1'b1; mInit = 1'b0; mIrq = 1'b0;
    end else begin
      mInit = 1'b0; mIrq = 1'b0;
      if (wrEn && portEnable) begin
        if (wrData[0]) begin
          mInit = 1'b1; mIrq = 1'b1; mA20 = 1'b1;
        end else if (wrData[1] != mA20) begin
          mA20 = wrData[1]; mIrq = 1'b1;
        end
      end
    end
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      chk("a20Gate", {7'b0, a20Gate}, {7'b0, mA20});
      chk("rdData", rdData, mA20 ? 8'h02 : 8'h00);
      chk("initPulse", {7'b0, initPulse}, {7'b0, mInit});
      chk("irqPulse", {7'b0, irqPulse}, {7'b0, mIrq});
    end
  end

  task automatic wr(logic [7:0] d, logic en);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; portEnable = en;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00; portEnable = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tag = "R1"; idle(2);
    tag = "R3"; wr(8'h00, 1'b1); idle(1); wr(8'h02, 1'b1); idle(1);
    tag = "R5"; wr(8'h02, 1'b1); wr(8'h02, 1'b1); idle(1);
    tag = "R2"; wr(8'h00, 1'b1); wr(8'h01, 1'b1); idle(2);
    tag = "R4"; wr(8'h00, 1'b1); wr(8'h01, 1'b1); idle(1); wr(8'h03, 1'b1); idle(1);
    tag = "R6"; wr(8'h01, 1'b1); wr(8'h01, 1'b1); idle(2);
    tag = "R7"; wr(8'hFE, 1'b1); wr(8'hFC, 1'b1); wr(8'hAE, 1'b1); idle(1);
    tag = "R8"; wr(8'h00, 1'b1); idle(1); wr(8'hFF, 1'b1); idle(1);
    tag = "R9"; wr(8'h00, 1'b0); wr(8'h01, 1'b0); idle(1);
    wr(8'h00, 1'b1); wr(8'h03, 1'b0); wr(8'h02, 1'b0); idle(2);
    tag = "R3"; wr(8'h02, 1'b1); idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule